// File: doc/BRIEF.md
# Scalable-Granularity System Counter

This block keeps the one system-wide count that every timer channel compares against. The count is a free-running up-counter, 64 bits wide by default. It starts at zero after reset and advances at a fixed effective rate, set by a base-rate tick pulse. Every comparator channel reads the same count as a plain bus, and the bus always shows the current value.

To save power, the count can be updated coarsely. In that mode it moves by a larger step less often: by 10 once every 10 ticks, or by 100 once every 100 ticks. The effective frequency stays the same. An internal divider counts base ticks within the current interval. A new step size is adopted only when an interval closes, so the count never departs from the value a step of 1 would have given at any interval boundary.

The block also holds a frequency-report register. Firmware writes it once after reset so that software can read the counter rate. Its value plays no part in counting.

Top module: `scnt_counter`

## Requirements
- R1: While reset is applied, and for two clocks after `rst_n` rises (synchronous release), `count` is 0, the step in force is 1 and `freq_value` is 0.
- R2: `step_sel` codes map as follows: 0 selects a step of 1, 1 selects 10, 2 selects 100, and the unused code 3 selects 1. With a step N in force, `count` stays unchanged for the first N−1 advancing ticks of an interval and rises by exactly N on the N-th.
- R3: A clock cycle advances the block only when `tick` and `enable` are both high. In any other cycle, `count` and the divider position both hold their values.
- R4: A new `step_sel` value is adopted only when an interval closes. The step in force never changes while the divider is part-way through an interval.
- R5: After every clock, `count` equals the number of advancing ticks since reset minus the ticks already taken in the open interval. That open-interval figure is always less than the step in force.
- R6: The count wraps modulo 2^CNT_W with no flag or other side effect.
- R7: The first `freq_wr` after reset loads `freq_wdata` into `freq_value`. Every later write is ignored until the next reset.
- R8: Writing or changing the frequency report never alters `count` or the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Base-rate tick pulse, one clock wide |
| enable | input | 1 | Counting enable; low freezes count and divider |
| step_sel | input | 2 | Requested update step code (0:1, 1:10, 2:100, 3:1) |
| freq_wr | input | 1 | Write strobe for the frequency report |
| freq_wdata | input | FREQ_W | Frequency value to record |
| freq_value | output | FREQ_W | Recorded counter frequency, read-only after the first write |
| count | output | CNT_W | Global system count |

## Verification
The count is tried against these stimulus patterns:
- Long constrained-random runs in which tick, enable and the step code all change freely. These show whether the count stays equal to the tick total minus the open-interval position, so any drift between step sizes is caught.
- Directed runs at a step of 10 and of 100. These show whether the count waits N−1 ticks and then jumps by exactly N, as opposed to moving early or by the wrong amount.
- A step change made part-way through an interval. This shows whether the old step is held until the boundary or adopted at once.
- Ticks sent while the enable is low. These separate a divider that holds from one that keeps running.
- A second instance 8 bits wide, which runs past its range. This shows whether the wrap is silent and modular.
- Repeated frequency writes made during counting. These confirm the write-once locking and that the report has no influence on the count.

// File: rtl/scnt_pkg.sv
package scnt_pkg;

  typedef enum logic [1:0] {
    STEP_FINE   = 2'd0,
    STEP_MEDIUM = 2'd1,
    STEP_COARSE = 2'd2,
    STEP_SPARE  = 2'd3
  } step_code_e;

  localparam int unsigned STEP_FINE_VAL   = 1;
  localparam int unsigned STEP_MEDIUM_VAL = 10;
  localparam int unsigned STEP_COARSE_VAL = 100;
  localparam int unsigned STEP_MAX_VAL    = STEP_COARSE_VAL;

  localparam int unsigned STEP_W = $clog2(STEP_MAX_VAL + 1);

  function automatic logic [STEP_W-1:0] step_of(input logic [1:0] code);
    logic [STEP_W-1:0] v;
    case (step_code_e'(code))
      STEP_MEDIUM: v = STEP_W'(STEP_MEDIUM_VAL);
      STEP_COARSE: v = STEP_W'(STEP_COARSE_VAL);
      default:     v = STEP_W'(STEP_FINE_VAL);
    endcase
    return v;
  endfunction

endpackage

// File: rtl/scnt_rst_sync.sv
module scnt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/scnt_divider.sv
module scnt_divider
  import scnt_pkg::*;
#(
  parameter int unsigned DIV_W = $clog2(STEP_MAX_VAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic [1:0]        step_req,
  output logic              interval_done,
  output logic [STEP_W-1:0] step_now,
  output logic [DIV_W-1:0]  div_pos
);

  logic [DIV_W-1:0]  div_q, div_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              div_en;
  logic              at_last;

  always_comb begin
    at_last = ({{(STEP_W > DIV_W ? STEP_W - DIV_W : 1){1'b0}}, div_q} ==
               ({{(STEP_W > DIV_W ? 1 : DIV_W - STEP_W + 1){1'b0}}, step_q} - 1'b1));
  end

  always_comb begin
    div_en        = advance;
    interval_done = advance && at_last;
    div_d         = div_q;
    step_d        = step_q;
    if (advance) begin
      if (at_last) begin
        div_d  = '0;
        step_d = step_of(step_req);
      end else begin
        div_d  = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      step_q <= STEP_W'(STEP_FINE_VAL);
    end else if (div_en) begin
      div_q  <= div_d;
      step_q <= step_d;
    end
  end

  assign step_now = step_q;
  assign div_pos  = div_q;

endmodule

// File: rtl/scnt_accum.sv
module scnt_accum
  import scnt_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bump,
  input  logic [STEP_W-1:0] amount,
  output logic [CNT_W-1:0]  count
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] amount_ext;

  generate
    if (CNT_W > STEP_W) begin : g_wide
      assign amount_ext = {{(CNT_W-STEP_W){1'b0}}, amount};
    end else begin : g_narrow
      assign amount_ext = amount[CNT_W-1:0];
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q + amount_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (bump) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/scnt_freq_reg.sv
module scnt_freq_reg #(
  parameter int unsigned FREQ_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [FREQ_W-1:0] wdata,
  output logic [FREQ_W-1:0] value,
  output logic              locked
);

  logic [FREQ_W-1:0] val_q;
  logic              lock_q;
  logic              load_en;

  always_comb begin
    load_en = wr && !lock_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      lock_q <= 1'b0;
    end else if (load_en) begin
      val_q  <= wdata;
      lock_q <= 1'b1;
    end
  end

  assign value  = val_q;
  assign locked = lock_q;

endmodule

// File: rtl/scnt_counter.sv
module scnt_counter
  import scnt_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned FREQ_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic [1:0]        step_sel,
  input  logic              freq_wr,
  input  logic [FREQ_W-1:0] freq_wdata,
  output logic [FREQ_W-1:0] freq_value,
  output logic [CNT_W-1:0]  count
);

  localparam int unsigned DIV_W = $clog2(STEP_MAX_VAL);

  logic              rst_sync_n;
  logic              advance;
  logic              interval_done;
  logic [STEP_W-1:0] step_now;
  logic [DIV_W-1:0]  div_pos;
  logic              freq_locked;

  assign advance = tick && enable;

  scnt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  scnt_divider #(.DIV_W(DIV_W)) u_div (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .advance       (advance),
    .step_req      (step_sel),
    .interval_done (interval_done),
    .step_now      (step_now),
    .div_pos       (div_pos)
  );

  scnt_accum #(.CNT_W(CNT_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .bump   (interval_done),
    .amount (step_now),
    .count  (count)
  );

  scnt_freq_reg #(.FREQ_W(FREQ_W)) u_freq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr     (freq_wr),
    .wdata  (freq_wdata),
    .value  (freq_value),
    .locked (freq_locked)
  );

endmodule

// File: rtl/scnt_counter_chk.sv
module scnt_counter_chk
  import scnt_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned FREQ_W = 32,
  parameter int unsigned DIV_W  = 7
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              tick,
  input logic              enable,
  input logic              freq_wr,
  input logic              freq_locked,
  input logic [FREQ_W-1:0] freq_value,
  input logic [CNT_W-1:0]  count,
  input logic [STEP_W-1:0] step_now,
  input logic [DIV_W-1:0]  div_pos
);

  logic [CNT_W-1:0] prev_q;
  logic [CNT_W-1:0] delta;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) prev_q <= '0;
    else             prev_q <= count;
  end

  assign delta = count - prev_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(tick && enable) |=> ($stable(count) && $stable(div_pos))); // R3

  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (delta == CNT_W'(0)) || (delta == CNT_W'(STEP_FINE_VAL)) ||
    (delta == CNT_W'(STEP_MEDIUM_VAL)) || (delta == CNT_W'(STEP_COARSE_VAL))); // R2

  AST_DIV_BELOW_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    32'(div_pos) < 32'(step_now)); // R5

  AST_STEP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(step_now) |-> (div_pos == '0)); // R4

  AST_FREQ_LOCKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (freq_locked && freq_wr) |=> $stable(freq_value)); // R7

endmodule

bind scnt_counter scnt_counter_chk #(
  .CNT_W  (CNT_W),
  .FREQ_W (FREQ_W),
  .DIV_W  (DIV_W)
) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .tick        (tick),
  .enable      (enable),
  .freq_wr     (freq_wr),
  .freq_locked (freq_locked),
  .freq_value  (freq_value),
  .count       (count),
  .step_now    (step_now),
  .div_pos     (div_pos)
);

// File: tb/scnt_counter_test.sv
module scnt_counter_test;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic        enable;
  logic [1:0]  step_sel;
  logic        freq_wr;
  logic [31:0] freq_wdata;
  logic [31:0] freq_value;
  logic [63:0] count;
  logic [31:0] freq_value_n;
  logic [7:0]  count_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model: advancing ticks, open-interval position, step in force
  logic [63:0] m_ticks;
  int          m_div;
  int          m_step;

  scnt_counter #(.CNT_W(64), .FREQ_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
    .step_sel(step_sel), .freq_wr(freq_wr), .freq_wdata(freq_wdata),
    .freq_value(freq_value), .count(count)
  );

  scnt_counter #(.CNT_W(8), .FREQ_W(32)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
    .step_sel(step_sel), .freq_wr(freq_wr), .freq_wdata(freq_wdata),
    .freq_value(freq_value_n), .count(count_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int code_step(input logic [1:0] c);
    case (c)
      2'd1:    return 10;
      2'd2:    return 100;
      default: return 1;
    endcase
  endfunction

  function automatic logic [63:0] exp_count(input logic [63:0] t, input int d);
    return t - 64'(d);
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ticks = '0;
    m_div   = 0;
    m_step  = 1;
  endtask

  // drive at negedge, model the posedge, compare at the following negedge
  task automatic cyc(input logic t, input logic e, input logic [1:0] s,
                     input logic fw, input logic [31:0] fd, input string req);
    tick = t; enable = e; step_sel = s; freq_wr = fw; freq_wdata = fd;
    @(posedge clk);
    if (t && e) begin
      m_ticks = m_ticks + 1;
      if (m_div == m_step - 1) begin
        m_div  = 0;
        m_step = code_step(s);
      end else begin
        m_div = m_div + 1;
      end
    end
    @(negedge clk);
    check64(req, count, exp_count(m_ticks, m_div));
    check64({req, " narrow"}, 64'(count_n), 64'(8'(exp_count(m_ticks, m_div))));
  endtask

  task automatic do_reset();
    tick = 0; enable = 0; step_sel = 0; freq_wr = 0; freq_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check64("R1 count in reset", count, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check64("R1 count after release", count, 64'd0);
    @(negedge clk);
    @(negedge clk);
    check64("R1 freq after release", 64'(freq_value), 64'd0);
    model_reset();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5C0F_1E22;
    void'($urandom(seed));
    rst_n = 1'b0;
    tick = 0; enable = 0; step_sel = 0; freq_wr = 0; freq_wdata = 0;
    @(negedge clk);
    do_reset();

    // R2 step of 1: every tick adds one
    for (int i = 0; i < 5; i++) cyc(1, 1, 2'd0, 0, 0, "R2 step1");
    check64("R2 five fine ticks", count, 64'd5);

    // R2 step of 10: adopted at next boundary (step 1 interval closes each tick)
    cyc(1, 1, 2'd1, 0, 0, "R2 adopt10");          // count 6, step 10 now
    for (int i = 0; i < 9; i++) begin
      cyc(1, 1, 2'd1, 0, 0, "R2 step10 wait");
      check64("R2 holds inside interval", count, 64'd6);
    end
    cyc(1, 1, 2'd1, 0, 0, "R2 step10 jump");
    check64("R2 jump by ten", count, 64'd16);

    // R4: switch to code 0 mid-interval; old step kept until boundary
    for (int i = 0; i < 5; i++) cyc(1, 1, 2'd1, 0, 0, "R4 part interval");
    for (int i = 0; i < 4; i++) cyc(1, 1, 2'd0, 0, 0, "R4 request step1");
    check64("R4 no early change", count, 64'd16);
    cyc(1, 1, 2'd0, 0, 0, "R4 boundary");
    check64("R4 old step closes", count, 64'd26);
    cyc(1, 1, 2'd0, 0, 0, "R4 new step");
    check64("R4 new step in force", count, 64'd27);

    // R3: ticks with enable low, and enable with no tick
    for (int i = 0; i < 6; i++) cyc(1, 0, 2'd2, 0, 0, "R3 disabled ticks");
    for (int i = 0; i < 6; i++) cyc(0, 1, 2'd2, 0, 0, "R3 no tick");
    check64("R3 held", count, 64'd27);

    // R2 step 100 with R7/R8 frequency writes during the run
    cyc(1, 1, 2'd2, 1, 32'd24_000_000, "R8 write during count");
    check64("R7 first write", 64'(freq_value), 64'd24_000_000);
    for (int i = 0; i < 99; i++)
      cyc(1, 1, 2'd2, (i % 7) == 0, 32'hDEAD_0000 + 32'(i), "R8 step100 wait");
    check64("R2 step100 waits", count, 64'd28);
    check64("R7 later writes ignored", 64'(freq_value), 64'd24_000_000);
    cyc(1, 1, 2'd2, 0, 0, "R2 step100 jump");
    check64("R2 jump by hundred", count, 64'd128);

    // R6: narrow instance passes 255 silently; code 3 selects step 1 (R2)
    for (int i = 0; i < 200; i++) cyc(1, 1, 2'd3, 0, 0, "R6 run past range");
    check64("R6 narrow wrapped", 64'(count_n), 64'(8'(exp_count(m_ticks, m_div))));

    // R5 constrained random
    for (int i = 0; i < 4000; i++) begin
      logic t, e, fw;
      logic [1:0] s;
      t  = ($urandom_range(0, 9) < 7);
      e  = ($urandom_range(0, 9) < 8);
      s  = 2'($urandom_range(0, 3));
      fw = ($urandom_range(0, 49) == 0);
      cyc(t, e, s, fw, $urandom, "R5 random");
    end
    check64("R7 lock survives random", 64'(freq_value), 64'd24_000_000);

    // R1: reset again mid-run
    do_reset();
    cyc(1, 1, 2'd1, 0, 0, "R1 step1 after reset");
    check64("R1 first tick after reset", count, 64'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule